// File: doc/BRIEF.md
# Low-Power Sleep Mode Controller

This block decides which low-power depth the processor core drops into when it executes a sleep instruction, and brings the core back to running when an interrupt becomes pending. The depth is chosen from the top bit of two standby control bytes that software has programmed beforehand. The first byte selects the deepest state, and the second selects an intermediate state. When neither bit is set, the core takes the lightest sleep, in which only the core itself halts.

The controller drives the current power state, a core-halt line, and clock enables for each peripheral group: the timer, the serial port and the power-management unit, plus a separate enable for the DMA engine. The intermediate depth stops only the DMA engine. The deepest depth also stops the peripheral groups, but only after one catch-up cycle in which they keep running so their state is current when the clock stops. An interrupt returns the core to running at the next clock edge.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the state becomes RUNNING (encoding 0), `core_halt` is 0, and every clock enable is 1.
- R2: A sleep request sampled in RUNNING with bit 7 of `stby_ctl_a` set moves the state to STANDBY (encoding 3) at that edge.
- R3: A sleep request sampled in RUNNING with bit 7 of `stby_ctl_a` clear and bit 7 of `stby_ctl_b` set moves the state to DEEP_SLEEP (encoding 2).
- R4: A sleep request sampled in RUNNING with both bit-7 values clear moves the state to SLEEP (encoding 1). Bits 6..0 of both bytes have no effect.
- R5: A sleep request sampled in any state other than RUNNING is ignored, and the state is unchanged.
- R6: With `irq_pending` high at an edge in any non-running state, the state becomes RUNNING at that edge.
- R7: `core_halt` is 1 exactly when the state is not RUNNING.
- R8: In STANDBY, `periph_clk_en` (bit 0 timer, bit 1 serial, bit 2 power management) stays all ones for the first cycle and is all zeros from the second cycle on. `dma_clk_en` is 0 throughout STANDBY.
- R9: In DEEP_SLEEP, `dma_clk_en` is 0 and `periph_clk_en` is all ones. In SLEEP and RUNNING, every enable is 1.
- R10: A sleep request in RUNNING is honoured even if `irq_pending` is high in the same cycle. The wakeup then follows on the next edge if the interrupt is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_req | input | 1 | Sleep instruction executed this cycle |
| stby_ctl_a | input | 8 | First standby control byte; bit 7 selects STANDBY |
| stby_ctl_b | input | 8 | Second standby control byte; bit 7 selects DEEP_SLEEP |
| irq_pending | input | 1 | An interrupt is pending |
| pwr_state | output | 2 | 0 RUNNING, 1 SLEEP, 2 DEEP_SLEEP, 3 STANDBY |
| core_halt | output | 1 | Core clock is stopped |
| periph_clk_en | output | 3 | Enables for timer, serial and power-management groups |
| dma_clk_en | output | 1 | DMA engine clock enable |

## Verification
Directed cases step through each bit-7 combination so that the three depths can be told apart. They also change only the low bits of the control bytes, to show that those bits do not affect the chosen depth. A sleep request is raised while the core is already asleep, and again together with an interrupt while running, to separate "request ignored" from "request honoured". A STANDBY entry held for several cycles shows the catch-up cycle before the peripheral enables drop. Random cycles with a fixed seed mix requests, interrupts, control bytes and occasional resets, and every cycle is compared against a bench model.

// File: rtl/pwr_sleep_pkg.sv
// Package: shared power-state encoding and field positions for the sleep controller.
// Assumes: state values are observed externally, so the encoding is fixed.
package pwr_sleep_pkg;
    typedef enum logic [1:0] {
        PS_RUN   = 2'd0,
        PS_LIGHT = 2'd1,
        PS_DEEP  = 2'd2,
        PS_STBY  = 2'd3
    } pwr_state_e;

    localparam int CTL_W       = 8;
    localparam int SEL_BIT     = 7;
    localparam int N_PERIPH    = 3;
endpackage

// File: rtl/pwr_depth_decode.sv
// Module: pwr_depth_decode
// Maps the two standby control bytes to the sleep depth that a request would
// enter. The first byte has priority over the second. Purely combinational.
module pwr_depth_decode
    import pwr_sleep_pkg::*;
#(
    parameter int W   = CTL_W,
    parameter int BIT = SEL_BIT
) (
    input  logic [W-1:0] ctl_a,
    input  logic [W-1:0] ctl_b,
    output pwr_state_e   depth
);
    // Priority pick: first byte wins, then second, else light sleep.
    always_comb begin
        if (ctl_a[BIT])      depth = PS_STBY;
        else if (ctl_b[BIT]) depth = PS_DEEP;
        else                 depth = PS_LIGHT;
    end
endmodule

// File: rtl/pwr_state_reg.sv
// Module: pwr_state_reg
// Holds the power state. A request is honoured only in RUNNING, and a pending
// interrupt wakes the core from any sleep state at the next edge.
// Assumes: synchronous active-low reset.
module pwr_state_reg
    import pwr_sleep_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  pwr_state_e req_depth,
    input  logic       irq_pending,
    output pwr_state_e state_q
);
    pwr_state_e state_d;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        if (state_q == PS_RUN) begin
            if (sleep_req) state_d = req_depth;
        end else if (irq_pending) begin
            state_d = PS_RUN;
        end
    end

    // State register with synchronous reset to RUNNING.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_RUN;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/pwr_clk_gate.sv
// Module: pwr_clk_gate
// Derives clock enables from the power state. The peripheral groups get one
// catch-up cycle after STANDBY entry before they stop. DMA stops in both deep
// states.
// Assumes: state input comes from a register.
module pwr_clk_gate
    import pwr_sleep_pkg::*;
#(
    parameter int NP = N_PERIPH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  pwr_state_e    state_q,
    output logic [NP-1:0] periph_en,
    output logic          dma_en
);
    logic stby_seen_q;
    logic periph_stop;

    // Tracks that STANDBY has already lasted one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) stby_seen_q <= 1'b0;
        else        stby_seen_q <= (state_q == PS_STBY);
    end

    // Peripheral stop once the catch-up cycle is over.
    always_comb periph_stop = (state_q == PS_STBY) && stby_seen_q;

    // One enable per peripheral group.
    for (genvar g = 0; g < NP; g++) begin : g_periph
        assign periph_en[g] = !periph_stop;
    end

    // DMA runs only in RUNNING and light sleep.
    always_comb dma_en = (state_q == PS_RUN) || (state_q == PS_LIGHT);
endmodule

// File: rtl/pwr_sleep_ctrl.sv
// Module: pwr_sleep_ctrl (top)
// Low-power sleep controller: selects the sleep depth on request, wakes on an
// interrupt, and drives the core halt and per-group clock enables.
// Assumes: sleep_req is a single-cycle pulse from the core; synchronous reset.
module pwr_sleep_ctrl
    import pwr_sleep_pkg::*;
#(
    parameter int CW = CTL_W,
    parameter int SB = SEL_BIT,
    parameter int NP = N_PERIPH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sleep_req,
    input  logic [CW-1:0] stby_ctl_a,
    input  logic [CW-1:0] stby_ctl_b,
    input  logic          irq_pending,
    output logic [1:0]    pwr_state,
    output logic          core_halt,
    output logic [NP-1:0] periph_clk_en,
    output logic          dma_clk_en
);
    pwr_state_e depth;
    pwr_state_e state_q;

    pwr_depth_decode #(.W(CW), .BIT(SB)) u_decode (
        .ctl_a (stby_ctl_a),
        .ctl_b (stby_ctl_b),
        .depth (depth)
    );

    pwr_state_reg u_state (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_req   (sleep_req),
        .req_depth   (depth),
        .irq_pending (irq_pending),
        .state_q     (state_q)
    );

    pwr_clk_gate #(.NP(NP)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_q   (state_q),
        .periph_en (periph_clk_en),
        .dma_en    (dma_clk_en)
    );

    // Output mapping of state and core halt.
    always_comb begin
        pwr_state = state_q;
        core_halt = (state_q != PS_RUN);
    end
endmodule

// File: rtl/pwr_sleep_ctrl_chk.sv
// Module: pwr_sleep_ctrl_chk
// Checker bound to the top; observes ports only.
module pwr_sleep_ctrl_chk #(
    parameter int CW = 8,
    parameter int SB = 7,
    parameter int NP = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sleep_req,
    input logic [CW-1:0] stby_ctl_a,
    input logic [CW-1:0] stby_ctl_b,
    input logic          irq_pending,
    input logic [1:0]    pwr_state,
    input logic          core_halt,
    input logic [NP-1:0] periph_clk_en,
    input logic          dma_clk_en
);
    AST_RESET_RUN: assert property (@(posedge clk) !rst_n |=> pwr_state == 2'd0); // R1
    AST_ENTER_STBY: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd0 && sleep_req && stby_ctl_a[SB]) |=> pwr_state == 2'd3); // R2
    AST_ENTER_DEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd0 && sleep_req && !stby_ctl_a[SB] && stby_ctl_b[SB]) |=> pwr_state == 2'd2); // R3
    AST_ENTER_LIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd0 && sleep_req && !stby_ctl_a[SB] && !stby_ctl_b[SB]) |=> pwr_state == 2'd1); // R4
    AST_ASLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state != 2'd0 && !irq_pending) |=> $stable(pwr_state)); // R5
    AST_IRQ_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state != 2'd0 && irq_pending) |=> pwr_state == 2'd0); // R6
    AST_HALT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        core_halt == (pwr_state != 2'd0)); // R7
    AST_STBY_CATCHUP: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd3 && $past(pwr_state) != 2'd3) |-> &periph_clk_en); // R8
    AST_STBY_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd3 && $past(pwr_state) == 2'd3) |-> periph_clk_en == '0); // R8
    AST_DEEP_DMA_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_state == 2'd2 |-> (!dma_clk_en && &periph_clk_en)); // R9
endmodule

bind pwr_sleep_ctrl pwr_sleep_ctrl_chk #(.CW(CW), .SB(SB), .NP(NP)) u_chk (.*);

// File: tb/pwr_sleep_ctrl_tb.sv
module pwr_sleep_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       sleep_req;
    logic [7:0] ctl_a, ctl_b;
    logic       irq;
    logic [1:0] pwr_state;
    logic       core_halt;
    logic [2:0] periph_en;
    logic       dma_en;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Bench model state
    int m_st   = 0;
    bit m_seen = 0;

    always #2 clk = ~clk;

    pwr_sleep_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
        .stby_ctl_a(ctl_a), .stby_ctl_b(ctl_b), .irq_pending(irq),
        .pwr_state(pwr_state), .core_halt(core_halt),
        .periph_clk_en(periph_en), .dma_clk_en(dma_en)
    );

    function automatic int next_st(int st, bit req, bit a7, bit b7, bit ip);
        if (st == 0) begin
            if (!req) return 0;
            if (a7) return 3;
            if (b7) return 2;
            return 1;
        end
        return ip ? 0 : st;
    endfunction

    function automatic logic [2:0] exp_periph(int st, bit seen);
        return (st == 3 && seen) ? 3'b000 : 3'b111;
    endfunction

    function automatic bit exp_dma(int st);
        return (st == 0 || st == 1);
    endfunction

    task automatic chk(string tag);
        total++;
        if (pwr_state != m_st[1:0] || core_halt != (m_st != 0) ||
            periph_en != exp_periph(m_st, m_seen) || dma_en != exp_dma(m_st)) begin
            bad++;
            $display("FAIL %s: state=%0d halt=%0b periph=%b dma=%0b expected state=%0d halt=%0b periph=%b dma=%0b",
                     tag, pwr_state, core_halt, periph_en, dma_en,
                     m_st, (m_st != 0), exp_periph(m_st, m_seen), exp_dma(m_st));
        end
    endtask

    // One cycle: apply inputs, clock, advance the model, compare outputs.
    task automatic cyc(bit rn, bit req, logic [7:0] a, logic [7:0] b, bit ip, string tag);
        rst_n = rn; sleep_req = req; ctl_a = a; ctl_b = b; irq = ip;
        @(posedge clk);
        if (!rn) begin
            m_st = 0; m_seen = 0;
        end else begin
            m_seen = (m_st == 3);
            m_st = next_st(m_st, req, a[7], b[7], ip);
        end
        #1;
        chk(tag);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        process::self().srandom(32'h5EED);
        cyc(0, 0, 0, 0, 0, "R1 reset");
        cyc(0, 1, 8'h80, 0, 0, "R1 reset with request");
        // R4: light sleep, low bits set must not matter
        cyc(1, 1, 8'h7F, 8'h7F, 0, "R4 light entry");
        cyc(1, 0, 0, 0, 0, "R9 light enables");
        cyc(1, 1, 8'h80, 0, 0, "R5 request ignored in sleep");
        cyc(1, 0, 0, 0, 1, "R6 wake from light");
        // R3: deep sleep
        cyc(1, 1, 8'h00, 8'h80, 0, "R3 deep entry");
        cyc(1, 1, 8'h80, 8'h80, 0, "R5 ignored in deep");
        cyc(1, 0, 0, 0, 1, "R6 wake from deep");
        // R2: standby with catch-up cycle
        cyc(1, 1, 8'h80, 8'h80, 0, "R2 standby entry R8 catch-up");
        cyc(1, 0, 0, 0, 0, "R8 standby stopped");
        cyc(1, 1, 0, 0, 0, "R5 ignored in standby");
        cyc(1, 0, 0, 0, 1, "R6 wake from standby");
        cyc(1, 0, 0, 0, 0, "R7 running");
        // R10: request and interrupt together
        cyc(1, 1, 0, 8'h80, 1, "R10 sleep honoured with irq");
        cyc(1, 0, 0, 0, 1, "R10 wake next edge");
        // Standby entered then immediate wake
        cyc(1, 1, 8'hFF, 0, 0, "R2 standby again");
        cyc(1, 0, 0, 0, 1, "R8 wake during catch-up");
        cyc(1, 1, 8'h80, 0, 0, "R2 re-entry");
        cyc(0, 0, 0, 0, 0, "R1 reset from standby");
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            bit rn  = ($urandom_range(0, 99) != 0);
            bit req = ($urandom_range(0, 3) == 0);
            bit ip  = ($urandom_range(0, 4) == 0);
            logic [7:0] a = 8'($urandom);
            logic [7:0] b = 8'($urandom);
            cyc(rn, req, a, b, ip, "R7 R8 R9 random");
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule